// File: doc/BRIEF.md
# CAN Fault Confinement Controller

This block keeps the fault-confinement standing of one CAN node. It holds a transmit error counter and a receive error counter. It moves them on single-cycle event strobes from the protocol engine: error or success, for transmit or receive. From the two counters it decides whether the node is error active, error passive or bus off. The framer sends its three kinds of bus drive through this block: data or remote frame transmission, error-flag drive and the ACK bit. The block blocks all three while the node is bus off or while listen-only mode is on.

Software can leave bus off at once with a one-cycle recovery command. The command zeroes both counters and the bus-off flag and returns the node to error active. Nothing else the node holds is touched, such as configuration or message storage. In listen-only mode the node watches the bus but stays silent. Any transmit request made in that mode is masked.

Top module: `can_fault_conf`

## Requirements
- R1: After reset both counters read 0, `bus_off_o` is 0 and `state_o` is 2'b00 (error active).
- R2: A transmit error strobe adds 8 to the transmit counter and a receive error strobe adds 1 to the receive counter. Each counter is 9 bits wide and saturates at 511.
- R3: A transmit success strobe subtracts 1 from the transmit counter and a receive success strobe subtracts 1 from the receive counter. Neither goes below 0. When an error strobe and a success strobe for the same counter come in the same cycle, only the error is applied.
- R4: Outside bus off, `state_o` is 2'b01 (error passive) when either counter is 128 or more. It is 2'b00 (error active) when both are below 128.
- R5: When the transmit counter goes above 255, the node enters bus off: `state_o` is 2'b10 and `bus_off_o` is 1. While in bus off every event strobe is ignored and both counters hold their values until recovery.
- R6: A recovery pulse in bus off clears both counters and `bus_off_o` and sets `state_o` to 2'b00. This is visible after the next clock edge, and takes priority over any event in the same cycle.
- R7: A recovery pulse outside bus off has no effect on the counters or the state.
- R8: While `listen_only_i` is 1, `tx_drive_o`, `err_frame_drive_o` and `ack_drive_o` are all 0, whatever is requested.
- R9: With listen-only off and outside bus off, each drive output follows its request input in the same cycle. In bus off all three drive outputs are 0.
- R10: An event strobe sampled at a clock edge shows in the counters, the state and the bus-off flag right after that same edge.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset, released synchronously inside |
| tx_err_i | input | 1 | Transmit error event strobe |
| rx_err_i | input | 1 | Receive error event strobe |
| tx_ok_i | input | 1 | Successful transmission strobe |
| rx_ok_i | input | 1 | Successful reception strobe |
| force_recover_i | input | 1 | One-cycle forced bus-off recovery command |
| listen_only_i | input | 1 | Listen-only mode enable |
| tx_req_i | input | 1 | Frame transmission drive request from the framer |
| err_frame_req_i | input | 1 | Error-flag drive request from the framer |
| ack_req_i | input | 1 | ACK bit drive request from the framer |
| state_o | output | 2 | Confinement state: 00 active, 01 passive, 10 bus off |
| tec_o | output | 9 | Transmit error counter |
| rec_o | output | 9 | Receive error counter |
| bus_off_o | output | 1 | Bus-off status flag |
| tx_drive_o | output | 1 | Gated frame transmission drive |
| err_frame_drive_o | output | 1 | Gated error-flag drive |
| ack_drive_o | output | 1 | Gated ACK drive |

## Verification
Every counter and state register is visible at the ports. A wrong increment, a missing floor or a missing ceiling therefore shows as a counter mismatch right after the edge that applied the event. A state or flag error has knock-on effects. A missed bus-off entry lets drive outputs through in the same cycle. A stuck flag keeps them blocked and freezes the counters from the next event on. The bench follows a step-by-step arithmetic model through targeted walks: to passive, back to active, to the floor, to saturation, into bus off and out of it. It then runs a long pseudo-random stretch, so any divergence is caught one cycle after it happens.

// File: rtl/can_fc_pkg.sv
package can_fc_pkg;
  typedef enum logic [1:0] {
    FC_ACTIVE  = 2'b00,
    FC_PASSIVE = 2'b01,
    FC_BUSOFF  = 2'b10
  } fc_state_e;

  // drive channel indices inside the gate vector
  localparam int unsigned DRV_ACK    = 0;
  localparam int unsigned DRV_ERRFRM = 1;
  localparam int unsigned DRV_DATA   = 2;
  localparam int unsigned NUM_DRV    = 3;
endpackage

// File: rtl/can_fc_rst_sync.sv
module can_fc_rst_sync #(
  parameter int unsigned STAGES = 2
) (
  input  logic clk,
  input  logic rst_n,
  output logic rst_sync_n
);
  logic [STAGES-1:0] sync_q;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      sync_q <= '0;
    end else begin
      sync_q <= {sync_q[STAGES-2:0], 1'b1};
    end
  end

  assign rst_sync_n = sync_q[STAGES-1];
endmodule

// File: rtl/can_fc_errcnt.sv
module can_fc_errcnt #(
  parameter int unsigned W   = 9,
  parameter int unsigned INC = 8
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic         clr_i,
  input  logic         hold_i,
  input  logic         err_i,
  input  logic         ok_i,
  output logic [W-1:0] cnt_o,
  output logic [W-1:0] cnt_nxt_o
);
  localparam logic [W:0]   INC_V = (W+1)'(INC);
  localparam logic [W:0]   MAX_V = {1'b0, {W{1'b1}}};

  logic [W-1:0] cnt_q;
  logic [W-1:0] cnt_nxt;
  logic [W:0]   sum;
  logic         cnt_en;

  assign sum    = {1'b0, cnt_q} + INC_V;
  assign cnt_en = clr_i | (~hold_i & (err_i | ok_i));

  // next-value logic: clear > hold > error > success
  always_comb begin
    cnt_nxt = cnt_q;
    if (clr_i) begin
      cnt_nxt = '0;
    end else if (!hold_i) begin
      if (err_i) begin
        cnt_nxt = (sum > MAX_V) ? MAX_V[W-1:0] : sum[W-1:0];
      end else if (ok_i && (cnt_q != '0)) begin
        cnt_nxt = cnt_q - 1'b1;
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      cnt_q <= '0;
    end else if (cnt_en) begin
      cnt_q <= cnt_nxt;
    end
  end

  assign cnt_o     = cnt_q;
  assign cnt_nxt_o = cnt_nxt;
endmodule

// File: rtl/can_fc_confine.sv
module can_fc_confine
  import can_fc_pkg::*;
#(
  parameter int unsigned W           = 9,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BUSOFF_LIM  = 255
) (
  input  logic         clk,
  input  logic         rst_n,
  input  logic [W-1:0] tec_nxt_i,
  input  logic [W-1:0] rec_nxt_i,
  input  logic         recover_i,
  output logic         bus_off_o,
  output logic         recover_hit_o,
  output fc_state_e    state_o
);
  localparam logic [W-1:0] PASS_L = W'(PASSIVE_LIM);
  localparam logic [W-1:0] BOFF_L = W'(BUSOFF_LIM);

  logic      bus_off_q;
  logic      bus_off_nxt;
  fc_state_e state_q;
  fc_state_e state_nxt;

  assign recover_hit_o = bus_off_q & recover_i;

  always_comb begin
    if (bus_off_q) begin
      bus_off_nxt = ~recover_i;
    end else begin
      bus_off_nxt = (tec_nxt_i > BOFF_L);
    end
  end

  always_comb begin
    if (bus_off_nxt) begin
      state_nxt = FC_BUSOFF;
    end else if ((tec_nxt_i >= PASS_L) || (rec_nxt_i >= PASS_L)) begin
      state_nxt = FC_PASSIVE;
    end else begin
      state_nxt = FC_ACTIVE;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      bus_off_q <= 1'b0;
      state_q   <= FC_ACTIVE;
    end else begin
      bus_off_q <= bus_off_nxt;
      state_q   <= state_nxt;
    end
  end

  assign bus_off_o = bus_off_q;
  assign state_o   = state_q;
endmodule

// File: rtl/can_fc_drvgate.sv
module can_fc_drvgate #(
  parameter int unsigned N = 3
) (
  input  logic [N-1:0] req_i,
  input  logic         listen_i,
  input  logic         bus_off_i,
  output logic [N-1:0] drv_o
);
  logic allow;
  assign allow = ~listen_i & ~bus_off_i;

  for (genvar g = 0; g < N; g++) begin : g_chan
    assign drv_o[g] = req_i[g] & allow;
  end
endmodule

// File: rtl/can_fault_conf.sv
module can_fault_conf
  import can_fc_pkg::*;
#(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned TX_ERR_INC  = 8,
  parameter int unsigned RX_ERR_INC  = 1,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BUSOFF_LIM  = 255
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             tx_err_i,
  input  logic             rx_err_i,
  input  logic             tx_ok_i,
  input  logic             rx_ok_i,
  input  logic             force_recover_i,
  input  logic             listen_only_i,
  input  logic             tx_req_i,
  input  logic             err_frame_req_i,
  input  logic             ack_req_i,
  output logic [1:0]       state_o,
  output logic [CNT_W-1:0] tec_o,
  output logic [CNT_W-1:0] rec_o,
  output logic             bus_off_o,
  output logic             tx_drive_o,
  output logic             err_frame_drive_o,
  output logic             ack_drive_o
);
  logic               rst_i_n;
  logic [CNT_W-1:0]   tec_nxt;
  logic [CNT_W-1:0]   rec_nxt;
  logic               bus_off;
  logic               recover_hit;
  fc_state_e          state;
  logic [NUM_DRV-1:0] req_vec;
  logic [NUM_DRV-1:0] drv_vec;

  can_fc_rst_sync #(.STAGES(2)) u_rst (
    .clk        (clk),
    .rst_n      (rst_n),
    .rst_sync_n (rst_i_n)
  );

  can_fc_errcnt #(.W(CNT_W), .INC(TX_ERR_INC)) u_tec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr_i     (recover_hit),
    .hold_i    (bus_off),
    .err_i     (tx_err_i),
    .ok_i      (tx_ok_i),
    .cnt_o     (tec_o),
    .cnt_nxt_o (tec_nxt)
  );

  can_fc_errcnt #(.W(CNT_W), .INC(RX_ERR_INC)) u_rec (
    .clk       (clk),
    .rst_n     (rst_i_n),
    .clr_i     (recover_hit),
    .hold_i    (bus_off),
    .err_i     (rx_err_i),
    .ok_i      (rx_ok_i),
    .cnt_o     (rec_o),
    .cnt_nxt_o (rec_nxt)
  );

  can_fc_confine #(
    .W           (CNT_W),
    .PASSIVE_LIM (PASSIVE_LIM),
    .BUSOFF_LIM  (BUSOFF_LIM)
  ) u_conf (
    .clk           (clk),
    .rst_n         (rst_i_n),
    .tec_nxt_i     (tec_nxt),
    .rec_nxt_i     (rec_nxt),
    .recover_i     (force_recover_i),
    .bus_off_o     (bus_off),
    .recover_hit_o (recover_hit),
    .state_o       (state)
  );

  always_comb begin
    req_vec             = '0;
    req_vec[DRV_DATA]   = tx_req_i;
    req_vec[DRV_ERRFRM] = err_frame_req_i;
    req_vec[DRV_ACK]    = ack_req_i;
  end

  can_fc_drvgate #(.N(NUM_DRV)) u_gate (
    .req_i     (req_vec),
    .listen_i  (listen_only_i),
    .bus_off_i (bus_off),
    .drv_o     (drv_vec)
  );

  assign state_o           = state;
  assign bus_off_o         = bus_off;
  assign tx_drive_o        = drv_vec[DRV_DATA];
  assign err_frame_drive_o = drv_vec[DRV_ERRFRM];
  assign ack_drive_o       = drv_vec[DRV_ACK];
endmodule

// File: rtl/can_fault_conf_chk.sv
module can_fault_conf_chk #(
  parameter int unsigned CNT_W       = 9,
  parameter int unsigned RX_ERR_INC  = 1,
  parameter int unsigned PASSIVE_LIM = 128,
  parameter int unsigned BUSOFF_LIM  = 255
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tx_err_i,
  input logic             rx_err_i,
  input logic             tx_ok_i,
  input logic             rx_ok_i,
  input logic             force_recover_i,
  input logic             listen_only_i,
  input logic [1:0]       state_o,
  input logic [CNT_W-1:0] tec_o,
  input logic [CNT_W-1:0] rec_o,
  input logic             bus_off_o,
  input logic             tx_drive_o,
  input logic             err_frame_drive_o,
  input logic             ack_drive_o
);
  localparam int MAXV = (1 << CNT_W) - 1;

  assert_rx_step_R2: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off_o && rx_err_i && (int'(rec_o) + int'(RX_ERR_INC) <= MAXV))
    |=> (int'(rec_o) == int'($past(rec_o)) + int'(RX_ERR_INC)));

  assert_tx_floor_R3: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off_o && tx_ok_i && !tx_err_i && tec_o == '0) |=> (tec_o == '0));

  assert_passive_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off_o && (int'(tec_o) >= int'(PASSIVE_LIM) || int'(rec_o) >= int'(PASSIVE_LIM)))
    |-> (state_o == 2'b01));

  assert_active_R4: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off_o && int'(tec_o) < int'(PASSIVE_LIM) && int'(rec_o) < int'(PASSIVE_LIM))
    |-> (state_o == 2'b00));

  assert_busoff_entry_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (int'(tec_o) > int'(BUSOFF_LIM)) |-> (bus_off_o && state_o == 2'b10));

  assert_busoff_hold_R5: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off_o && !force_recover_i) |=> (bus_off_o && $stable(tec_o) && $stable(rec_o)));

  assert_recover_clears_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_off_o && force_recover_i)
    |=> (tec_o == '0 && rec_o == '0 && !bus_off_o && state_o == 2'b00));

  assert_recover_ignored_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (!bus_off_o && force_recover_i && !tx_err_i && !rx_err_i && !tx_ok_i && !rx_ok_i)
    |=> ($stable(tec_o) && $stable(rec_o) && $stable(state_o)));

  assert_listen_silent_R8: assert property (@(posedge clk) disable iff (!rst_n)
    listen_only_i |-> (!tx_drive_o && !err_frame_drive_o && !ack_drive_o));

  assert_busoff_silent_R9: assert property (@(posedge clk) disable iff (!rst_n)
    bus_off_o |-> (!tx_drive_o && !err_frame_drive_o && !ack_drive_o));
endmodule

bind can_fault_conf can_fault_conf_chk #(
  .CNT_W       (CNT_W),
  .RX_ERR_INC  (RX_ERR_INC),
  .PASSIVE_LIM (PASSIVE_LIM),
  .BUSOFF_LIM  (BUSOFF_LIM)
) chk_i (
  .clk               (clk),
  .rst_n             (rst_n),
  .tx_err_i          (tx_err_i),
  .rx_err_i          (rx_err_i),
  .tx_ok_i           (tx_ok_i),
  .rx_ok_i           (rx_ok_i),
  .force_recover_i   (force_recover_i),
  .listen_only_i     (listen_only_i),
  .state_o           (state_o),
  .tec_o             (tec_o),
  .rec_o             (rec_o),
  .bus_off_o         (bus_off_o),
  .tx_drive_o        (tx_drive_o),
  .err_frame_drive_o (err_frame_drive_o),
  .ack_drive_o       (ack_drive_o)
);

// File: tb/can_fault_conf_tb_top.sv
`timescale 1ns/1ps
module can_fault_conf_tb_top;
  logic       clk;
  logic       rst_n;
  logic       tx_err_i, rx_err_i, tx_ok_i, rx_ok_i;
  logic       force_recover_i, listen_only_i;
  logic       tx_req_i, err_frame_req_i, ack_req_i;
  logic [1:0] state_o;
  logic [8:0] tec_o, rec_o;
  logic       bus_off_o, tx_drive_o, err_frame_drive_o, ack_drive_o;

  int checks = 0;
  int errors = 0;
  int m_tec  = 0;
  int m_rec  = 0;
  bit m_bo   = 1'b0;
  logic [31:0] lfsr = 32'hACE1_2468;

  can_fault_conf dut_i (
    .clk               (clk),
    .rst_n             (rst_n),
    .tx_err_i          (tx_err_i),
    .rx_err_i          (rx_err_i),
    .tx_ok_i           (tx_ok_i),
    .rx_ok_i           (rx_ok_i),
    .force_recover_i   (force_recover_i),
    .listen_only_i     (listen_only_i),
    .tx_req_i          (tx_req_i),
    .err_frame_req_i   (err_frame_req_i),
    .ack_req_i         (ack_req_i),
    .state_o           (state_o),
    .tec_o             (tec_o),
    .rec_o             (rec_o),
    .bus_off_o         (bus_off_o),
    .tx_drive_o        (tx_drive_o),
    .err_frame_drive_o (err_frame_drive_o),
    .ack_drive_o       (ack_drive_o)
  );

  initial clk = 1'b0;
  always #4 clk = ~clk;

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0d expected %0d", tag, what, act, exp);
    end
  endtask

  function automatic int exp_state();
    if (m_bo) return 2;
    if (m_tec >= 128 || m_rec >= 128) return 1;
    return 0;
  endfunction

  // Called at a falling edge: drive, check gates, advance model, check at next falling edge.
  task automatic step(input string tag, input bit txe, input bit rxe, input bit txo,
                      input bit rxo, input bit frc, input bit lo,
                      input bit tr, input bit er, input bit ar);
    string gtag;
    bit    allow;
    tx_err_i = txe; rx_err_i = rxe; tx_ok_i = txo; rx_ok_i = rxo;
    force_recover_i = frc; listen_only_i = lo;
    tx_req_i = tr; err_frame_req_i = er; ack_req_i = ar;
    #1;
    gtag  = lo ? "R8" : "R9";
    allow = !lo && !m_bo;
    chk(tx_drive_o == (tr && allow), gtag, "tx_drive", tx_drive_o, tr && allow);
    chk(err_frame_drive_o == (er && allow), gtag, "err_frame_drive", err_frame_drive_o, er && allow);
    chk(ack_drive_o == (ar && allow), gtag, "ack_drive", ack_drive_o, ar && allow);
    if (m_bo) begin
      if (frc) begin
        m_tec = 0; m_rec = 0; m_bo = 1'b0;
      end
    end else begin
      if (txe) m_tec = (m_tec + 8 > 511) ? 511 : m_tec + 8;
      else if (txo && m_tec > 0) m_tec = m_tec - 1;
      if (rxe) m_rec = (m_rec + 1 > 511) ? 511 : m_rec + 1;
      else if (rxo && m_rec > 0) m_rec = m_rec - 1;
      m_bo = (m_tec > 255);
    end
    @(negedge clk);
    chk(int'(tec_o) == m_tec, tag, "tec", tec_o, m_tec);
    chk(int'(rec_o) == m_rec, tag, "rec", rec_o, m_rec);
    chk(bus_off_o == m_bo, tag, "bus_off", bus_off_o, m_bo);
    chk(int'(state_o) == exp_state(), tag, "state", state_o, exp_state());
  endtask

  task automatic idle(input string tag);
    step(tag, 0, 0, 0, 0, 0, 0, 0, 0, 0);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    rst_n = 1'b0;
    tx_err_i = 0; rx_err_i = 0; tx_ok_i = 0; rx_ok_i = 0;
    force_recover_i = 0; listen_only_i = 0;
    tx_req_i = 0; err_frame_req_i = 0; ack_req_i = 0;
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    repeat (4) @(negedge clk);
    // R1 reset state
    chk(tec_o == 9'd0, "R1", "tec", tec_o, 0);
    chk(rec_o == 9'd0, "R1", "rec", rec_o, 0);
    chk(bus_off_o == 1'b0, "R1", "bus_off", bus_off_o, 0);
    chk(state_o == 2'b00, "R1", "state", state_o, 0);

    // R2 / R4: receive errors into passive, R3 back down to floor
    for (int i = 0; i < 130; i++) step((i >= 126) ? "R4" : "R2", 0, 1, 0, 0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 5; i++)   step("R4", 0, 0, 0, 1, 0, 0, 0, 1, 0);
    for (int i = 0; i < 130; i++) step("R3", 0, 0, 0, 1, 0, 0, 1, 0, 1);
    // R3 error wins over success in the same cycle
    for (int i = 0; i < 3; i++)   step("R3", 1, 1, 1, 1, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++)   step("R3", 0, 0, 1, 1, 0, 0, 0, 0, 0);

    // R7 recovery outside bus off does nothing
    for (int i = 0; i < 4; i++) step("R7", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    step("R7", 0, 0, 0, 0, 1, 0, 1, 1, 1);
    step("R7", 0, 0, 0, 0, 1, 1, 1, 1, 1);

    // R8 listen-only silences every drive
    for (int i = 0; i < 8; i++) step("R8", 0, 0, 0, 0, 0, 1, i[0], i[1], i[2]);
    for (int i = 0; i < 8; i++) step("R9", 0, 0, 0, 0, 0, 0, i[0], i[1], i[2]);

    // R5: transmit errors through passive into bus off; events ignored there
    for (int i = 0; i < 36; i++) step((i >= 14) ? "R5" : "R4", 1, 0, 0, 0, 0, 0, 1, 1, 1);
    for (int i = 0; i < 6; i++)  step("R5", 0, 1, 1, 1, 0, 0, 1, 1, 1);
    // R6 recovery from bus off, with concurrent events overridden
    step("R6", 1, 1, 0, 0, 1, 0, 1, 1, 1);
    idle("R6");

    // R2 saturation of the receive counter
    for (int i = 0; i < 520; i++) step("R2", 0, 1, 0, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 3; i++)   step("R3", 0, 0, 1, 0, 0, 0, 0, 0, 0);
    for (int i = 0; i < 520; i++) step("R3", 0, 0, 0, 1, 0, 0, 0, 0, 0);

    // R10 pseudo-random event mix
    for (int i = 0; i < 4000; i++) begin
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      lfsr = {lfsr[30:0], lfsr[31] ^ lfsr[21] ^ lfsr[1] ^ lfsr[0]};
      step("R10", lfsr[1:0] == 2'b00, lfsr[4:2] == 3'b000, lfsr[6:5] == 2'b00,
           lfsr[8:7] != 2'b11, lfsr[13:9] == 5'd0, lfsr[15:14] == 2'b00,
           lfsr[16], lfsr[17], lfsr[18]);
    end

    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule